// File: doc/BRIEF.md
# Timed Power-Mode Sequencer

This block keeps a processor core in one of three operating modes: full-speed run, idle with the core clock stopped but logic still powered, and sleep with most of the logic switched off. A power policy elsewhere asks for a mode on a request port. An asynchronous-origin wakeup event, already synchronised, pulls the core back to run. No move between modes is instant. Each move passes through a transitional period whose length in clock cycles is a parameter, and each pair of modes has its own length. The lengths are strongly asymmetric: leaving sleep takes far longer than any other move.

The block drives the core clock enable, the logic power enable and a busy flag. While a move is in flight it reports a distinct transitional mode code. It also keeps a running energy figure. Every cycle it adds the power weight of the mode held in that cycle to a wide accumulator. Transitional cycles are charged at the run weight. A combinational break-even pair tells the policy whether a planned low-power stay of a given length repays the time lost in entering and leaving that mode.

Top module: `pwr_mode_fsm`

## Requirements
- R1: While reset is asserted, and right after it is released, the outputs are as follows: mode reads 0 (run), busy is 0, both enables are 1 and energy is 0.
- R2: Mode codes are 0 run, 1 idle, 2 sleep and 3 transition. In run, a valid request for idle (req_mode 1) gives T_RUN_IDLE cycles of transition and then idle. In run or idle, a valid request for sleep (req_mode 2) gives T_SLEEP_IN cycles of transition and then sleep.
- R3: In idle, wake or a valid request for run (req_mode 0) gives T_IDLE_RUN cycles of transition and then run. Wake takes precedence over a simultaneous sleep request.
- R4: In sleep, wake or a valid request for run or idle gives T_WAKE cycles of transition and always ends in run.
- R5: busy is 1 exactly while mode reads 3. Requests and wake that arrive during a transition have no effect on its target or its length.
- R6: In a stable mode, the following have no effect: a request for the current mode, the reserved request code 3, and wake while in run.
- R7: core_clk_en is 0 exactly in idle and sleep. logic_pwr_en is 0 exactly in sleep. Both are 1 during transitions.
- R8: At every clock after reset, energy grows by W_RUN, W_IDLE or W_SLEEP, chosen by the mode held in that cycle. Transition cycles use W_RUN.
- R9: idle_worth is 1 exactly when stay_cycles > T_RUN_IDLE + T_IDLE_RUN. sleep_worth is 1 exactly when stay_cycles > T_SLEEP_IN + T_WAKE. Both are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested mode: 0 run, 1 idle, 2 sleep, 3 reserved |
| wake | input | 1 | Wakeup event, forces a return to run from idle or sleep |
| stay_cycles | input | STAY_W | Planned low-power stay in cycles, for break-even |
| mode | output | 2 | Current mode: 0 run, 1 idle, 2 sleep, 3 transition |
| core_clk_en | output | 1 | Core clock enable |
| logic_pwr_en | output | 1 | Logic power enable |
| busy | output | 1 | Transition in progress |
| energy | output | ACC_W | Accumulated weighted energy |
| idle_worth | output | 1 | Planned stay repays an idle round trip |
| sleep_worth | output | 1 | Planned stay repays a sleep round trip |

## Verification
The hardest case to reach from the ports is the long return from sleep while requests and wake pulses keep arriving. Random traffic alone seldom holds steady long enough for sleep to be entered and then fully exited. A directed sequence therefore walks run to idle to sleep. It then counts the busy cycles of the wake-up while it keeps firing conflicting requests. Long random stretches with a low request rate follow. A cycle model in the bench tracks mode and energy through every one of these stretches.

// File: rtl/pwr_mode_fsm.sv
`timescale 1ns/1ps
module pwr_mode_fsm #(
  parameter int T_RUN_IDLE = 10,
  parameter int T_IDLE_RUN = 10,
  parameter int T_SLEEP_IN = 90,
  parameter int T_WAKE     = 1600,
  parameter int W_RUN      = 40000,
  parameter int W_IDLE     = 5000,
  parameter int W_SLEEP    = 16,
  parameter int ACC_W      = 48,
  parameter int STAY_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic              wake,
  input  logic [STAY_W-1:0] stay_cycles,
  output logic [1:0]        mode,
  output logic              core_clk_en,
  output logic              logic_pwr_en,
  output logic              busy,
  output logic [ACC_W-1:0]  energy,
  output logic              idle_worth,
  output logic              sleep_worth
);
  localparam logic [1:0] M_RUN = 2'd0, M_IDLE = 2'd1, M_SLEEP = 2'd2, M_TRANS = 2'd3;
  localparam int MAX_A = (T_RUN_IDLE > T_IDLE_RUN) ? T_RUN_IDLE : T_IDLE_RUN;
  localparam int MAX_B = (T_SLEEP_IN > T_WAKE) ? T_SLEEP_IN : T_WAKE;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAX_T + 1);
  localparam longint TH_IDLE  = longint'(T_RUN_IDLE) + longint'(T_IDLE_RUN);
  localparam longint TH_SLEEP = longint'(T_SLEEP_IN) + longint'(T_WAKE);

  logic [1:0]       mode_q, tgt_q, nxt_tgt;
  logic [CW-1:0]    cnt_q, nxt_cnt;
  logic [ACC_W-1:0] acc_q, weight;
  logic             go;

  always_comb begin
    go      = 1'b0;
    nxt_tgt = M_RUN;
    nxt_cnt = CW'(T_IDLE_RUN - 1);
    case (mode_q)
      M_RUN: if (req_valid) begin
        if (req_mode == M_IDLE) begin
          go = 1'b1; nxt_tgt = M_IDLE; nxt_cnt = CW'(T_RUN_IDLE - 1);
        end else if (req_mode == M_SLEEP) begin
          go = 1'b1; nxt_tgt = M_SLEEP; nxt_cnt = CW'(T_SLEEP_IN - 1);
        end
      end
      M_IDLE: begin
        if (wake || (req_valid && req_mode == M_RUN)) begin
          go = 1'b1; nxt_tgt = M_RUN; nxt_cnt = CW'(T_IDLE_RUN - 1);
        end else if (req_valid && req_mode == M_SLEEP) begin
          go = 1'b1; nxt_tgt = M_SLEEP; nxt_cnt = CW'(T_SLEEP_IN - 1);
        end
      end
      M_SLEEP: if (wake || (req_valid && (req_mode == M_RUN || req_mode == M_IDLE))) begin
        go = 1'b1; nxt_tgt = M_RUN; nxt_cnt = CW'(T_WAKE - 1);
      end
      default: ;
    endcase
  end

  always_comb begin
    case (mode_q)
      M_IDLE:  weight = ACC_W'(W_IDLE);
      M_SLEEP: weight = ACC_W'(W_SLEEP);
      default: weight = ACC_W'(W_RUN);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_RUN;
      tgt_q  <= M_RUN;
      cnt_q  <= '0;
      acc_q  <= '0;
    end else begin
      acc_q <= acc_q + weight;
      if (mode_q == M_TRANS) begin
        if (cnt_q == '0) mode_q <= tgt_q;
        else             cnt_q  <= cnt_q - 1'b1;
      end else if (go) begin
        mode_q <= M_TRANS;
        tgt_q  <= nxt_tgt;
        cnt_q  <= nxt_cnt;
      end
    end
  end

  assign mode         = mode_q;
  assign busy         = (mode_q == M_TRANS);
  assign core_clk_en  = (mode_q == M_RUN) || (mode_q == M_TRANS);
  assign logic_pwr_en = (mode_q != M_SLEEP);
  assign energy       = acc_q;
  assign idle_worth   = longint'(stay_cycles) > TH_IDLE;
  assign sleep_worth  = longint'(stay_cycles) > TH_SLEEP;
endmodule

// File: rtl/pwr_mode_fsm_chk.sv
`timescale 1ns/1ps
module pwr_mode_fsm_chk #(
  parameter int W_RUN   = 40000,
  parameter int W_IDLE  = 5000,
  parameter int W_SLEEP = 16,
  parameter int ACC_W   = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             wake,
  input logic [1:0]       mode,
  input logic             busy,
  input logic             core_clk_en,
  input logic             logic_pwr_en,
  input logic [ACC_W-1:0] energy
);
  function automatic logic [ACC_W-1:0] wt(input logic [1:0] m);
    return (m == 2'd1) ? ACC_W'(W_IDLE) : (m == 2'd2) ? ACC_W'(W_SLEEP) : ACC_W'(W_RUN);
  endfunction

  a_r5_busy_in_trans: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (mode == 2'd3));
  a_r7_core_clock: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en == (mode == 2'd0 || mode == 2'd3));
  a_r7_logic_power: assert property (@(posedge clk) disable iff (!rst_n)
    logic_pwr_en == (mode != 2'd2));
  a_r8_energy_step: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> energy == $past(energy) + wt($past(mode)));
  a_r6_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd3 && !req_valid && !wake) |=> $stable(mode));
  a_r4_sleep_exits_via_trans: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |=> (mode == 2'd2 || mode == 2'd3));
  a_r2_no_direct_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd3) |=> (mode == 2'd3 || $stable(mode)));
endmodule

bind pwr_mode_fsm pwr_mode_fsm_chk #(
  .W_RUN(W_RUN), .W_IDLE(W_IDLE), .W_SLEEP(W_SLEEP), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .wake(wake),
  .mode(mode), .busy(busy), .core_clk_en(core_clk_en),
  .logic_pwr_en(logic_pwr_en), .energy(energy)
);

// File: tb/pwr_mode_fsm_bench.sv
`timescale 1ns/1ps
module pwr_mode_fsm_bench;
  localparam int T_RI = 10, T_IR = 10, T_SI = 90, T_WK = 1600;
  localparam int WR = 40000, WI = 5000, WS = 16, AW = 48, SW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req_valid, wake, core_clk_en, logic_pwr_en, busy, idle_worth, sleep_worth;
  logic [1:0] req_mode, mode;
  logic [SW-1:0] stay_cycles;
  logic [AW-1:0] energy;

  pwr_mode_fsm u_pwr_mode_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .wake(wake), .stay_cycles(stay_cycles), .mode(mode), .core_clk_en(core_clk_en),
    .logic_pwr_en(logic_pwr_en), .busy(busy), .energy(energy),
    .idle_worth(idle_worth), .sleep_worth(sleep_worth)
  );

  int checks = 0, fails = 0;
  logic [1:0] m_mode, m_tgt;
  int m_cnt;
  logic [AW-1:0] m_acc;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] wt(input logic [1:0] m);
    return (m == 2'd1) ? AW'(WI) : (m == 2'd2) ? AW'(WS) : AW'(WR);
  endfunction

  task automatic model_edge(input bit rv, input logic [1:0] rm, input bit w);
    m_acc = m_acc + wt(m_mode);
    if (m_mode == 2'd3) begin
      if (m_cnt == 0) m_mode = m_tgt; else m_cnt--;
    end else if (m_mode == 2'd0) begin
      if (rv && rm == 2'd1) begin m_mode = 2'd3; m_tgt = 2'd1; m_cnt = T_RI - 1; end
      else if (rv && rm == 2'd2) begin m_mode = 2'd3; m_tgt = 2'd2; m_cnt = T_SI - 1; end
    end else if (m_mode == 2'd1) begin
      if (w || (rv && rm == 2'd0)) begin m_mode = 2'd3; m_tgt = 2'd0; m_cnt = T_IR - 1; end
      else if (rv && rm == 2'd2) begin m_mode = 2'd3; m_tgt = 2'd2; m_cnt = T_SI - 1; end
    end else begin
      if (w || (rv && (rm == 2'd0 || rm == 2'd1))) begin m_mode = 2'd3; m_tgt = 2'd0; m_cnt = T_WK - 1; end
    end
  endtask

  task automatic compare();
    chk(mode == m_mode, "R2 R3 R4 R6", "mode", mode, m_mode);
    chk(busy == (m_mode == 2'd3), "R5", "busy", busy, m_mode == 2'd3);
    chk(core_clk_en == (m_mode == 2'd0 || m_mode == 2'd3), "R7", "core_clk_en",
        core_clk_en, m_mode == 2'd0 || m_mode == 2'd3);
    chk(logic_pwr_en == (m_mode != 2'd2), "R7", "logic_pwr_en", logic_pwr_en, m_mode != 2'd2);
    chk(energy == m_acc, "R8", "energy", energy, m_acc);
  endtask

  task automatic step(input bit rv, input logic [1:0] rm, input bit w, input logic [SW-1:0] st);
    req_valid = rv; req_mode = rm; wake = w; stay_cycles = st;
    #1;
    chk(idle_worth == (longint'(st) > T_RI + T_IR), "R9", "idle_worth", idle_worth, longint'(st) > T_RI + T_IR);
    chk(sleep_worth == (longint'(st) > T_SI + T_WK), "R9", "sleep_worth", sleep_worth, longint'(st) > T_SI + T_WK);
    @(posedge clk);
    model_edge(rv, rm, w);
    @(negedge clk);
    compare();
  endtask

  task automatic count_busy(input int exp, input string tag);
    int n = 0;
    while (busy && n < 5000) begin
      n++;
      step(1'b1, 2'(n % 4), n[0], 32'd0);
    end
    chk(n == exp, tag, "transition length", n, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; req_valid = 1'b0; req_mode = 2'd0; wake = 1'b0; stay_cycles = '0;
    repeat (3) @(negedge clk);
    chk(mode == 2'd0 && !busy && core_clk_en && logic_pwr_en && energy == '0,
        "R1", "reset state", {mode, busy, core_clk_en, logic_pwr_en}, 3);
    m_mode = 2'd0; m_tgt = 2'd0; m_cnt = 0; m_acc = '0;
    rst_n = 1'b1;
    #1;
    chk(energy == '0 && mode == 2'd0, "R1", "after release", energy, 0);

    step(1'b1, 2'd3, 1'b0, 32'd5);  // R6 reserved code
    step(1'b1, 2'd0, 1'b0, 32'd5);  // R6 same mode
    step(1'b0, 2'd0, 1'b1, 32'd5);  // R6 wake in run
    chk(mode == 2'd0, "R6", "run held", mode, 0);

    step(1'b1, 2'd1, 1'b0, 32'd0);
    count_busy(T_RI, "R2 R5");
    chk(mode == 2'd1 && !core_clk_en && logic_pwr_en, "R7", "idle enables", mode, 1);
    step(1'b1, 2'd1, 1'b0, 32'd0);  // R6 same mode in idle
    step(1'b1, 2'd2, 1'b0, 32'd0);
    count_busy(T_SI, "R2 R5");
    chk(mode == 2'd2 && !logic_pwr_en, "R7", "sleep enables", mode, 2);
    step(1'b1, 2'd2, 1'b0, 32'd0);
    step(1'b1, 2'd3, 1'b0, 32'd0);
    chk(mode == 2'd2, "R6", "sleep held", mode, 2);
    step(1'b1, 2'd1, 1'b0, 32'd0);  // R4 idle request from sleep still ends in run
    count_busy(T_WK, "R4 R5");
    chk(mode == 2'd0, "R4", "sleep exit to run", mode, 0);
    step(1'b1, 2'd1, 1'b0, 32'd0);
    count_busy(T_RI, "R2");
    step(1'b1, 2'd2, 1'b1, 32'd0);  // R3 wake beats sleep request
    count_busy(T_IR, "R3");
    chk(mode == 2'd0, "R3", "idle exit to run", mode, 0);

    step(1'b0, 2'd0, 1'b0, 32'(T_RI + T_IR));
    step(1'b0, 2'd0, 1'b0, 32'(T_RI + T_IR + 1));
    step(1'b0, 2'd0, 1'b0, 32'(T_SI + T_WK));
    step(1'b0, 2'd0, 1'b0, 32'(T_SI + T_WK + 1));
    step(1'b0, 2'd0, 1'b0, 32'hFFFF_FFFF);

    for (int i = 0; i < 40000; i++) begin
      bit rv = ($urandom_range(0, 15) == 0);
      bit w  = ($urandom_range(0, 63) == 0);
      logic [1:0] rm = 2'($urandom_range(0, 3));
      logic [SW-1:0] st = ($urandom_range(0, 1) == 0) ? 32'($urandom_range(0, 2000)) : $urandom;
      step(rv, rm, w, st);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule